// File: doc/BRIEF.md
# Pipelined Exception Control Unit

This block decides, every cycle, whether a five-stage in-order pipeline must abandon its normal fetch stream to enter a trap handler. It watches three synchronous fault flags: a hardware-malfunction error reported by the memory stage, an arithmetic overflow reported by the execute stage and an undefined-opcode flag reported by the decode stage. It also watches an external interrupt line. Each flag counts only while the stage that raises it holds a valid instruction.

When more than one source is active, the block serves the one belonging to the oldest instruction, which is the one deepest in the pipeline. In the same cycle it steers the fetch multiplexer to the handler address. It also turns the faulting instruction and everything younger into bubbles. On the next clock edge it records the faulting PC and a cause code in two software-visible registers.

A mode pin chooses between two handler layouts. One sends every cause to a single base address. The other adds a per-cause offset to that base.

An interrupt is taken only when no synchronous fault is pending. It is taken on the instruction sitting in decode, which is then squashed so that it re-executes after the handler returns.

Top module: `exc_ctrl_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `sepc_o` and `scause_o` read zero until the first trap is taken; with all flags low, `pc_redirect` is 0.
- R2: Priority is memory-stage malfunction, then execute-stage overflow, then decode-stage undefined opcode, then interrupt; the PC of the chosen stage is written into `sepc_o`.
- R3: The cause codes written into `scause_o` are: undefined opcode 0, overflow 1, malfunction 2, and interrupt 0x8000_0000_0000_0000 (only the top bit set).
- R4: With `vec_mode` = 0, `pc_target` equals the base 0x1C09_0000 for every cause.
- R5: With `vec_mode` = 1, `pc_target` is the base plus a per-cause offset: undefined opcode 0x040, overflow 0x0C0, interrupt 0x100, malfunction 0x180.
- R6: Redirect and flushes are asserted in the same cycle as the winning flag. `flush_ifid` and `flush_idex` are set for any trap. `flush_exmem` is set when the winner is in execute or memory. `wr_suppress` is set only when the winner is in memory.
- R7: The interrupt is taken only when `id_valid` is 1 and no synchronous fault is active; `sepc_o` then holds `id_pc`.
- R8: `sepc_o` and `scause_o` take their new values at the clock edge that ends the trap cycle. They hold their values in every cycle with no trap.
- R9: A fault flag whose stage valid bit is 0 has no effect: no redirect, no flush, no register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the trap registers |
| vec_mode | input | 1 | 0: single handler address; 1: per-cause offsets |
| irq | input | 1 | External interrupt request |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_undef | input | 1 | Decode found an undefined opcode |
| id_pc | input | 64 | PC of the decode-stage instruction |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_ovf | input | 1 | Execute produced an arithmetic overflow |
| ex_pc | input | 64 | PC of the execute-stage instruction |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_hwerr | input | 1 | Hardware malfunction reported in memory stage |
| mem_pc | input | 64 | PC of the memory-stage instruction |
| pc_redirect | output | 1 | Select the trap input of the fetch multiplexer |
| pc_target | output | 64 | Handler fetch address |
| flush_ifid | output | 1 | Bubble the fetch/decode register |
| flush_idex | output | 1 | Bubble the decode/execute register |
| flush_exmem | output | 1 | Bubble the execute/memory register |
| wr_suppress | output | 1 | Block the register write of the memory-stage instruction |
| sepc_o | output | 64 | Trapping PC register |
| scause_o | output | 64 | Trap cause register |

## Verification
The bench sweeps every combination of the three valid bits, three fault flags, interrupt line and mode. Each pattern uses distinct PCs per stage, so a design that captured the wrong stage's PC in `sepc_o` cannot pass by accident. Simultaneous faults catch an arbiter that favours the younger instruction, which would record overflow instead of malfunction and leave `wr_suppress` low. Interrupt-plus-fault cases catch an interrupt allowed to pre-empt a synchronous fault. Patterns with a raised flag but a cleared valid bit catch flags that are not qualified. A trap-free cycle after each trap catches registers that keep reloading instead of holding.

// File: rtl/exc_pkg.sv
package exc_pkg;

    // Trap sources; arbiter index order is oldest-first
    typedef enum logic [1:0] {
        SRC_HW    = 2'd0,
        SRC_OVF   = 2'd1,
        SRC_UNDEF = 2'd2,
        SRC_IRQ   = 2'd3
    } trap_src_e;

    localparam int unsigned NUM_SRC = 4;

    function automatic trap_src_e idx_to_src(input logic [1:0] idx);
        return trap_src_e'(idx);
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
    parameter int unsigned N    = 4,
    parameter int unsigned XLEN = 64,
    localparam int unsigned IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic [N-1:0][XLEN-1:0] pc_in,
    output logic [N-1:0]         grant,
    output logic                 any,
    output logic [IW-1:0]        idx,
    output logic [XLEN-1:0]      pc_sel
);

    // Lowest index wins: it is the oldest instruction
    always_comb begin
        grant  = '0;
        idx    = '0;
        pc_sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant  = '0;
                grant[i] = 1'b1;
                idx    = IW'(i);
                pc_sel = pc_in[i];
            end
        end
    end

    assign any = |req;

    assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (any == (grant != '0)));

    assert_grant_from_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_pkg::*;
#(
    parameter int unsigned     XLEN      = 64,
    parameter logic [XLEN-1:0] BASE      = 64'h1C09_0000,
    parameter logic [XLEN-1:0] OFF_UNDEF = 64'h040,
    parameter logic [XLEN-1:0] OFF_OVF   = 64'h0C0,
    parameter logic [XLEN-1:0] OFF_IRQ   = 64'h100,
    parameter logic [XLEN-1:0] OFF_HW    = 64'h180
) (
    input  logic            vec_mode,
    input  trap_src_e       src,
    output logic [XLEN-1:0] target
);

    logic [XLEN-1:0] offset;

    always_comb begin
        unique case (src)
            SRC_UNDEF: offset = OFF_UNDEF;
            SRC_OVF:   offset = OFF_OVF;
            SRC_HW:    offset = OFF_HW;
            default:   offset = OFF_IRQ;
        endcase
        target = vec_mode ? (BASE + offset) : BASE;
    end

endmodule

// File: rtl/exc_csr.sv
module exc_csr
    import exc_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  trap_src_e       src,
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] sepc,
    output logic [XLEN-1:0] scause
);

    localparam logic [XLEN-1:0] IRQ_CODE = {1'b1, {(XLEN-1){1'b0}}};

    typedef struct packed {
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
    } csr_t;

    csr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.epc = pc;
            unique case (src)
                SRC_UNDEF: st_d.cause = XLEN'(0);
                SRC_OVF:   st_d.cause = XLEN'(1);
                SRC_HW:    st_d.cause = XLEN'(2);
                default:   st_d.cause = IRQ_CODE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sepc   = st_q.epc;
    assign scause = st_q.cause;

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(sepc) && $stable(scause)));

    assert_capture_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> sepc == $past(pc));

endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
    import exc_pkg::*;
#(
    parameter int unsigned     XLEN      = 64,
    parameter logic [XLEN-1:0] BASE      = 64'h1C09_0000,
    parameter logic [XLEN-1:0] OFF_UNDEF = 64'h040,
    parameter logic [XLEN-1:0] OFF_OVF   = 64'h0C0,
    parameter logic [XLEN-1:0] OFF_IRQ   = 64'h100,
    parameter logic [XLEN-1:0] OFF_HW    = 64'h180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vec_mode,
    input  logic            irq,
    input  logic            id_valid,
    input  logic            id_undef,
    input  logic [XLEN-1:0] id_pc,
    input  logic            ex_valid,
    input  logic            ex_ovf,
    input  logic [XLEN-1:0] ex_pc,
    input  logic            mem_valid,
    input  logic            mem_hwerr,
    input  logic [XLEN-1:0] mem_pc,
    output logic            pc_redirect,
    output logic [XLEN-1:0] pc_target,
    output logic            flush_ifid,
    output logic            flush_idex,
    output logic            flush_exmem,
    output logic            wr_suppress,
    output logic [XLEN-1:0] sepc_o,
    output logic [XLEN-1:0] scause_o
);

    localparam int unsigned IW = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0]           req, grant;
    logic [NUM_SRC-1:0][XLEN-1:0] pcs;
    logic [IW-1:0]                win_idx;
    logic [XLEN-1:0]              win_pc;
    logic                         take;
    logic                         sync_fault;
    trap_src_e                    win_src;

    // Qualify each flag with its stage valid; interrupt needs a boundary
    always_comb begin
        req[SRC_HW]    = mem_valid & mem_hwerr;
        req[SRC_OVF]   = ex_valid & ex_ovf;
        req[SRC_UNDEF] = id_valid & id_undef;
        sync_fault     = req[SRC_HW] | req[SRC_OVF] | req[SRC_UNDEF];
        req[SRC_IRQ]   = irq & id_valid & ~sync_fault;
        pcs[SRC_HW]    = mem_pc;
        pcs[SRC_OVF]   = ex_pc;
        pcs[SRC_UNDEF] = id_pc;
        pcs[SRC_IRQ]   = id_pc;
    end

    exc_arbiter #(.N(NUM_SRC), .XLEN(XLEN)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .pc_in  (pcs),
        .grant  (grant),
        .any    (take),
        .idx    (win_idx),
        .pc_sel (win_pc)
    );

    assign win_src = idx_to_src(win_idx);

    exc_vector #(
        .XLEN(XLEN), .BASE(BASE), .OFF_UNDEF(OFF_UNDEF),
        .OFF_OVF(OFF_OVF), .OFF_IRQ(OFF_IRQ), .OFF_HW(OFF_HW)
    ) u_vec (
        .vec_mode (vec_mode),
        .src      (win_src),
        .target   (pc_target)
    );

    exc_csr #(.XLEN(XLEN)) u_csr (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .src    (win_src),
        .pc     (win_pc),
        .sepc   (sepc_o),
        .scause (scause_o)
    );

    // Squash the winner and everything younger in the trap cycle
    always_comb begin
        pc_redirect = take;
        flush_ifid  = take;
        flush_idex  = take;
        flush_exmem = grant[SRC_HW] | grant[SRC_OVF];
        wr_suppress = grant[SRC_HW];
    end

    assert_oldest_recorded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_hwerr) |=> (sepc_o == $past(mem_pc) && scause_o == XLEN'(2)));

    assert_fixed_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_redirect && !vec_mode) |-> pc_target == BASE);

    assert_suppress_only_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_suppress |-> (mem_valid && mem_hwerr && flush_exmem && pc_redirect));

    assert_irq_yields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ex_valid && ex_ovf) |=> !scause_o[XLEN-1]);

    assert_invalid_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_valid && !ex_valid && !id_valid) |-> !pc_redirect);

endmodule

// File: tb/tb_exc_ctrl_unit.sv
module tb_exc_ctrl_unit;

    localparam time         CLK_PERIOD = 10;
    localparam logic [63:0] BASE       = 64'h1C09_0000;
    localparam logic [63:0] IRQ_CAUSE  = 64'h8000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n, vec_mode, irq;
    logic        id_valid, id_undef, ex_valid, ex_ovf, mem_valid, mem_hwerr;
    logic [63:0] id_pc, ex_pc, mem_pc;
    logic        pc_redirect, flush_ifid, flush_idex, flush_exmem, wr_suppress;
    logic [63:0] pc_target, sepc_o, scause_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_ctrl_unit dut (
        .clk(clk), .rst_n(rst_n), .vec_mode(vec_mode), .irq(irq),
        .id_valid(id_valid), .id_undef(id_undef), .id_pc(id_pc),
        .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
        .mem_valid(mem_valid), .mem_hwerr(mem_hwerr), .mem_pc(mem_pc),
        .pc_redirect(pc_redirect), .pc_target(pc_target),
        .flush_ifid(flush_ifid), .flush_idex(flush_idex),
        .flush_exmem(flush_exmem), .wr_suppress(wr_suppress),
        .sepc_o(sepc_o), .scause_o(scause_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] exp_sepc, exp_cause;
        rst_n = 1'b0; vec_mode = 1'b0; irq = 1'b0;
        id_valid = 1'b0; id_undef = 1'b0; ex_valid = 1'b0; ex_ovf = 1'b0;
        mem_valid = 1'b0; mem_hwerr = 1'b0;
        id_pc = '0; ex_pc = '0; mem_pc = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "sepc in reset", sepc_o, 64'h0);
        check("R1", "scause in reset", scause_o, 64'h0);
        check("R1", "redirect idle", {63'b0, pc_redirect}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", "sepc after release", sepc_o, 64'h0);
        check("R1", "scause after release", scause_o, 64'h0);
        exp_sepc = '0; exp_cause = '0;

        for (int k = 0; k < 512; k++) begin
            logic hw, ov, ud, it, tk;
            logic [63:0] e_pc, e_cause, e_off;
            logic [3:0]  e_fl;
            string tag;
            @(negedge clk);
            // even k: trap-free idle cycle to prove registers hold
            if (k[0]) begin
                {vec_mode, irq, id_valid, id_undef, ex_valid, ex_ovf,
                 mem_valid, mem_hwerr} = 8'(k >> 1);
            end else begin
                {vec_mode, irq, id_valid, id_undef, ex_valid, ex_ovf,
                 mem_valid, mem_hwerr} = 8'h0;
            end
            mem_pc = 64'h0000_0002_0000_0000 + 64'(k) * 64'h40;
            ex_pc  = mem_pc + 64'h4;
            id_pc  = mem_pc + 64'h8;
            #1;
            hw = mem_valid & mem_hwerr;
            ov = ex_valid & ex_ovf;
            ud = id_valid & id_undef;
            it = irq & id_valid & ~(hw | ov | ud);
            tk = hw | ov | ud | it;
            if (hw)      begin e_pc = mem_pc; e_cause = 64'd2; e_off = 64'h180; e_fl = 4'b1111; tag = "R2"; end
            else if (ov) begin e_pc = ex_pc;  e_cause = 64'd1; e_off = 64'h0C0; e_fl = 4'b1110; tag = "R2"; end
            else if (ud) begin e_pc = id_pc;  e_cause = 64'd0; e_off = 64'h040; e_fl = 4'b1100; tag = "R3"; end
            else if (it) begin e_pc = id_pc;  e_cause = IRQ_CAUSE; e_off = 64'h100; e_fl = 4'b1100; tag = "R7"; end
            else begin
                e_pc = exp_sepc; e_cause = exp_cause; e_off = 64'h0; e_fl = 4'b0000;
                tag = (mem_hwerr | ex_ovf | id_undef | irq) ? "R9" : "R8";
            end
            check(tag, "redirect", {63'b0, pc_redirect}, {63'b0, tk});
            check("R6", "flush/suppress",
                  {60'b0, flush_ifid, flush_idex, flush_exmem, wr_suppress}, {60'b0, e_fl});
            if (tk) begin
                if (vec_mode) check("R5", "vectored target", pc_target, BASE + e_off);
                else          check("R4", "fixed target", pc_target, BASE);
            end
            @(posedge clk); #1;
            exp_sepc = e_pc; exp_cause = e_cause;
            check(tk ? "R2" : "R8", "sepc", sepc_o, exp_sepc);
            check(tk ? "R3" : "R8", "scause", scause_o, exp_cause);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule